// File: doc/BRIEF.md
# Paired-Channel Interrupt Priority Controller

This block collects eight external interrupt event lines, arranged as four pairs (E, F, G, H), and decides which of them the processor should serve next. Each pair has a two-bit field in a software-writable priority register. The channel's three-bit level is that field with one more bit appended. The appended bit is 0 for the even member of the pair and 1 for the odd member, so the two channels of a pair never share a level. Level 0 is the most urgent and level 7 the least.

Every channel keeps a pending bit, which an event pulse sets and a clear strobe resets. A channel also raises an overrun flag if another event arrives while its pending bit is still set. The controller holds a request line high while anything is pending. It presents the index and level of the winning channel from a register stage. Software reaches the priority, pending and overrun registers through a small synchronous write, combinational read register port.

The request output is a plain level, not a valid/ready stream. There is no back-pressure. The request stays up until the served channel is cleared through its clear strobe, and the winner outputs follow the pending state on their own.

Top module: `paired_irq_ctrl`

## Requirements
- R1: Address 0 is the priority register, readable and writable, reset value 0xFF. Bits [1:0] belong to pair E (channels 0, 1), bits [3:2] to pair F (channels 2, 3), bits [5:4] to pair G (channels 4, 5) and bits [7:6] to pair H (channels 6, 7). A write appears on a read one cycle later.
- R2: The level of channel i is {field of pair i/2, i mod 2}, so the field supplies level bits 2:1. A lower number is more urgent.
- R3: A one-cycle pulse on evt_i[i] sets pending bit i. Address 1 reads the pending bits, bit i = channel i (E0=0, E1=1, F0=2, F1=3, G0=4, G1=5, H0=6, H1=7). The reset value is 0.
- R4: Overrun bit i sets when evt_i[i] arrives while pending bit i is already set and clr_i[i] is low. Address 2 reads the overrun bits with the same bit map as R3. The reset value is 0.
- R5: clr_i[i] clears pending bit i and overrun bit i. If evt_i[i] is high in the same cycle, the pending bit stays set and the overrun bit is still cleared.
- R6: irq_o is high exactly when at least one pending bit is set. It changes in the same cycle as the pending register.
- R7: The winner is the pending channel with the lowest level. Equal levels can only occur between pairs, and the lower channel index then wins (E, then F, then G, then H).
- R8: win_idx_o and win_lvl_o are registered. They reflect the pending bits and priority register of the previous cycle, and both read 0 when nothing was pending.
- R9: Writes to addresses 1, 2 and 3 change no state. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| evt_i | input | 8 | One-cycle event pulses, bit i = channel i |
| clr_i | input | 8 | Pending-clear strobes, bit i = channel i |
| irq_o | output | 1 | Request: some channel is pending |
| win_idx_o | output | 3 | Index of the winning channel |
| win_lvl_o | output | 3 | Level of the winning channel |

## Verification
The hardest situations to reach are an event and a clear landing on an already-overrun channel in the same cycle, and a tie between two pairs. The bench reaches the first by sending two events to one channel and then driving its event and clear together. It then reads back that the pending bit survives while the overrun flag drops. It reaches the second by rewriting the priority register so that two pair fields match, and then raising the even channels of both pairs. A pseudo-random phase mixes events, clears and priority writes so that many pending patterns pass through the arbiter. Each pattern is compared against a bench model written from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PRIO = 2'd0,
    ADDR_PEND = 2'd1,
    ADDR_OVR  = 2'd2,
    ADDR_RSVD = 2'd3
  } pic_addr_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int FIELD_W   = 2,
  parameter int BUS_W     = 8,
  localparam int NUM_CH   = 2 * NUM_PAIRS,
  localparam int PRIO_W   = NUM_PAIRS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] ovr_i,
  output logic [PRIO_W-1:0] prio_o,
  output logic [BUS_W-1:0]  rdata_o
);
  pic_addr_e addr_e;
  assign addr_e = pic_addr_e'(addr_i);

  logic [PRIO_W-1:0] prio_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prio_q <= '1;
    else if (wr_i && addr_e == ADDR_PRIO)
      prio_q <= wdata_i[PRIO_W-1:0];
  end
  assign prio_o = prio_q;

  always_comb begin
    rdata_o = '0;
    case (addr_e)
      ADDR_PRIO: rdata_o = BUS_W'(prio_q);
      ADDR_PEND: rdata_o = BUS_W'(pend_i);
      ADDR_OVR:  rdata_o = BUS_W'(ovr_i);
      default:   rdata_o = '0;
    endcase
  end

  // R1: a write reaches the priority register on the next cycle
  assert_prio_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_e == ADDR_PRIO) |=> (prio_q == $past(wdata_i[PRIO_W-1:0])));

  // R9: writes elsewhere leave the priority untouched
  assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_e != ADDR_PRIO) |=> $stable(prio_q));
endmodule

// File: rtl/pic_chan.sv
module pic_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o,
  output logic ovr_o
);
  logic pend_q, ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= evt_i | (pend_q & ~clr_i);
      if (clr_i)
        ovr_q <= 1'b0;
      else if (evt_i && pend_q)
        ovr_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;

  // R3: an event always leaves the channel pending
  assert_evt_sets_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> pend_q);

  // R4: second event while pending and not cleared raises overrun
  assert_second_evt_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && pend_q && !clr_i) |=> ovr_q);

  // R4: overrun can only exist alongside a pending bit
  assert_ovr_needs_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> pend_q);

  // R5: a clear without an event empties both bits
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> (!pend_q && !ovr_q));

  // R5: clear always drops the overrun flag
  assert_clear_drops_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !ovr_q);
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int NUM_PAIRS = 4,
  parameter int FIELD_W   = 2,
  localparam int NUM_CH   = 2 * NUM_PAIRS,
  localparam int PRIO_W   = NUM_PAIRS * FIELD_W,
  localparam int LVL_W    = FIELD_W + 1,
  localparam int IDX_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic [LVL_W-1:0]  win_lvl_o
);
  logic [LVL_W-1:0] lvl [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    assign lvl[g] = {prio_i[(g/2)*FIELD_W +: FIELD_W], 1'(g % 2)};
  end

  logic             found;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] best_lvl;

  // Ascending scan with strict compare: lower index keeps ties
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_i[i] && (!found || lvl[i] < best_lvl)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_idx_o <= '0;
      win_lvl_o <= '0;
    end else begin
      win_idx_o <= best_idx;
      win_lvl_o <= best_lvl;
    end
  end

  // R8: nothing pending yields a zero winner one cycle later
  assert_idle_winner_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend_i) |=> (win_idx_o == '0 && win_lvl_o == '0));

  // R7: the reported winner was pending in the cycle it was chosen from
  assert_winner_was_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i) |=> ((($past(pend_i) >> win_idx_o) & NUM_CH'(1)) != '0));
endmodule

// File: rtl/paired_irq_ctrl.sv
module paired_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int FIELD_W   = 2,
  parameter int BUS_W     = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [BUS_W-1:0]                  bus_wdata,
  output logic [BUS_W-1:0]                  bus_rdata,
  input  logic [2*NUM_PAIRS-1:0]            evt_i,
  input  logic [2*NUM_PAIRS-1:0]            clr_i,
  output logic                              irq_o,
  output logic [$clog2(2*NUM_PAIRS)-1:0]    win_idx_o,
  output logic [FIELD_W:0]                  win_lvl_o
);
  localparam int NUM_CH = 2 * NUM_PAIRS;
  localparam int PRIO_W = NUM_PAIRS * FIELD_W;

  logic [NUM_CH-1:0] pend, ovr;
  logic [PRIO_W-1:0] prio;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pic_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[c]),
      .clr_i  (clr_i[c]),
      .pend_o (pend[c]),
      .ovr_o  (ovr[c])
    );
  end

  pic_regs #(.NUM_PAIRS(NUM_PAIRS), .FIELD_W(FIELD_W), .BUS_W(BUS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .pend_i  (pend),
    .ovr_i   (ovr),
    .prio_o  (prio),
    .rdata_o (bus_rdata)
  );

  pic_arb #(.NUM_PAIRS(NUM_PAIRS), .FIELD_W(FIELD_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .prio_i    (prio),
    .win_idx_o (win_idx_o),
    .win_lvl_o (win_lvl_o)
  );

  assign irq_o = |pend;

  // R6: the request rises after any event
  assert_req_after_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> irq_o);
endmodule

// File: tb/tb_paired_irq_ctrl.sv
module tb_paired_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, evt, clr;
  logic       irq;
  logic [2:0] win_idx, win_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  paired_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt), .clr_i(clr),
    .irq_o(irq), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];
  event  sample_ev;
  int    n_run = 0, n_fail = 0;
  bit    finished = 0;
  bit [7:0] m_prio, m_pend, m_ovr;

  // Monitor: pop expectations, compare against the ports
  item_t      it;
  logic [7:0] act;
  always begin
    @(sample_ev);
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {7'b0, irq};
        2: act = {5'b0, win_idx};
        default: act = {5'b0, win_lvl};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  function automatic bit [5:0] model_win();
    int     best = -1;
    bit [2:0] bl = 0, l;
    for (int i = 0; i < 8; i++) begin
      l = {m_prio[2*(i/2) +: 2], i[0]};
      if (m_pend[i] && (best < 0 || l < bl)) begin
        best = i;
        bl   = l;
      end
    end
    return (best < 0) ? 6'd0 : {best[2:0], bl};
  endfunction

  task automatic push(input int k, input logic [7:0] v, input string tag);
    item_t x;
    x.kind = k; x.exp = v; x.tag = tag;
    sbq.push_back(x);
    -> sample_ev;
    #1;
  endtask

  task automatic step(input [7:0] e, input [7:0] c, input bit we,
                      input [1:0] a, input [7:0] wd);
    evt = e; clr = c; bus_wr = we; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    if (we && a == 2'd0) m_prio = wd;
    m_ovr  = (m_ovr & ~c) | (e & m_pend & ~c);
    m_pend = (m_pend & ~c) | e;
    @(negedge clk);
    evt = '0; clr = '0; bus_wr = 1'b0;
  endtask

  task automatic read_chk(input [1:0] a, input logic [7:0] v, input string tag);
    bus_addr = a; #1;
    push(0, v, tag);
  endtask

  // Idle cycle so the registered winner settles, then compare everything
  task automatic check_state();
    bit [5:0] w;
    step('0, '0, 1'b0, 2'd0, '0);
    w = model_win();
    read_chk(2'd0, m_prio, "R1");
    read_chk(2'd1, m_pend, "R3");
    read_chk(2'd2, m_ovr,  "R4");
    push(1, {7'b0, |m_pend}, "R6");
    push(2, {5'b0, w[5:3]}, "R7");
    push(3, {5'b0, w[2:0]}, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit [7:0] lf;
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; evt = 0; clr = 0;
    m_prio = 8'hFF; m_pend = 0; m_ovr = 0;
    repeat (3) @(negedge clk);
    // reset state: R1 R3 R4 R8
    read_chk(2'd0, 8'hFF, "R1");
    read_chk(2'd1, 8'h00, "R3");
    read_chk(2'd2, 8'h00, "R4");
    push(2, 8'h00, "R8");
    rst_n = 1'b1;
    @(negedge clk);

    step(8'h08, 0, 0, 0, 0); check_state();              // F1 alone, level 7
    step(8'h04, 0, 0, 0, 0); check_state();              // F0 level 6 wins: R2
    step(0, 0, 1, 2'd0, 8'h3F); check_state();            // pair H field 00: R1
    step(8'h80, 0, 0, 0, 0); check_state();              // H1 level 1 wins: R2
    step(8'h80, 0, 0, 0, 0); check_state();              // second H1 event: R4
    step(0, 8'h80, 0, 0, 0); check_state();              // clear H1: R5
    step(8'h04, 0, 0, 0, 0); check_state();              // F0 overrun: R4
    step(8'h04, 8'h04, 0, 0, 0); check_state();          // evt+clr together: R5
    read_chk(2'd1, 8'h0C, "R5");
    read_chk(2'd2, 8'h00, "R5");

    // tie between pairs: all fields 00, F0 and G0 pending -> F0 (R7)
    step(0, 8'hFF, 1, 2'd0, 8'h00);
    step(8'h14, 0, 0, 0, 0); check_state();
    push(2, 8'd2, "R7");

    // writes to read-only addresses ignored; address 3 reads zero (R9)
    step(0, 0, 1, 2'd1, 8'hFF);
    step(0, 0, 1, 2'd2, 8'hFF);
    step(0, 0, 1, 2'd3, 8'hFF);
    read_chk(2'd0, 8'h00, "R9");
    read_chk(2'd1, 8'h14, "R9");
    read_chk(2'd2, 8'h00, "R9");
    read_chk(2'd3, 8'h00, "R9");

    // clear all -> request low, winner zero (R6, R8)
    step(0, 8'hFF, 0, 0, 0); check_state();
    push(2, 8'h00, "R8");

    // winner lags the pending register by one cycle (R8)
    step(8'h20, 0, 0, 0, 0);
    push(1, 8'h01, "R6");
    push(2, 8'h00, "R8");
    step(0, 0, 0, 0, 0);
    push(2, 8'd5, "R8");
    step(0, 8'hFF, 0, 0, 0);

    // pseudo-random mix of events, clears and priority writes
    lf = 8'hA5;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (n % 5 == 0)
        step(lf & 8'h33, 0, 1, 2'd0, lf ^ 8'h5A);
      else
        step(lf, {lf[3:0], lf[7:4]} & 8'h96, 0, 0, 0);
      check_state();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule